// File: doc/BRIEF.md
# Buffer RAM Write-Protection Control Register

This block holds the one-byte control register that decides which parts of an emulated-EEPROM buffer RAM refuse writes. Software reaches the register over a simple synchronous register bus with address, write enable, write data and read data. After every reset the block first asks a nonvolatile-memory read port for a configuration byte and copies that byte into the register. Until that load finishes, the register keeps a fully locked value and every buffer RAM write is refused.

The register has three live fields. The open flag, when 0, protects the whole 1 KB buffer window. The range-disable flag, when 0 and the open flag is 1, switches on a protected range at the top of the window. The 3-bit size field sets how many 64-byte segments that range spans. Software can only move the two flags toward protection; it can never move them back. The size field freezes once range protection is on. A new reset is the only way to lower protection. The block checks each buffer RAM write address against the current register value and asserts `wr_block` when that write must be refused.

Top module: `bufram_wprot_ctrl`

## Requirements
- R1: From reset until the configuration load completes, `load_done` is 0, `nv_req` is 1, the register reads 0x07, and `wr_block` follows `ram_we` for every address.
- R2: In the cycle `nv_ack` is 1 while a load is pending, the register takes `nv_data` and `load_done` becomes 1. From then on `nv_req` stays 0.
- R3: If `nv_err` is 1 together with `nv_ack`, the register loads 0x07 (open 0, reserved 000, range-disable 0, size 111) and ignores `nv_data`.
- R4: Open flag (bit 7): a register write with data bit 7 = 0 clears it. A write with bit 7 = 1 leaves it unchanged, so it can never go from 0 to 1.
- R5: Range-disable flag (bit 3): a register write with data bit 3 = 0 clears it. A write with bit 3 = 1 leaves it unchanged.
- R6: Size field (bits 2:0) takes the written value only when the range-disable flag is 1 just before the write, including a write that clears that flag in the same cycle. Otherwise it is unchanged.
- R7: Bits 6:4 always read the value that was loaded and ignore every write.
- R8: While the open flag is 0, every buffer write (`ram_we` = 1) has `wr_block` = 1, whatever the other fields hold.
- R9: With open = 1 and range-disable = 0, a buffer write has `wr_block` = 1 exactly when `ram_addr` >= 1024 − (size+1)×64.
- R10: With open = 1 and range-disable = 1, no buffer write is blocked. `wr_block` is 0 whenever `ram_we` is 0.
- R11: `bus_rdata` is registered. One cycle after `bus_addr` equals 0x9 it shows the register; for any other address it reads 0x00. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the configuration load |
| bus_addr | input | 4 | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Registered read data |
| nv_req | output | 1 | Request for the configuration byte |
| nv_ack | input | 1 | Configuration byte valid |
| nv_data | input | 8 | Configuration byte |
| nv_err | input | 1 | Uncorrectable error on the configuration read |
| load_done | output | 1 | Configuration load finished |
| ram_we | input | 1 | Buffer RAM write attempt |
| ram_addr | input | 10 | Buffer RAM byte address within the window |
| wr_block | output | 1 | Buffer RAM write must be refused |

## Verification
Assertions check on every cycle that the two flags never rise after the load, that the size field and reserved bits stay frozen when they must, that a closed or unloaded register blocks every write, that the request ends once the load is done, and that reads from other addresses return zero. Only the bench's scenarios can show the exact value each write leaves in the register and the exact boundary address of the protected range. The bench sweeps every loaded byte over every buffer address, and every write byte over all flag and size combinations, and covers load errors and a write that clears range-disable and sets the size in the same cycle.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  // Register byte layout: bit 7 open, 6:4 reserved, 3 range-disable, 2:0 size
  typedef struct packed {
    logic       open;
    logic [2:0] rsv;
    logic       rdis;
    logic [2:0] size;
  } prot_t;

  localparam prot_t PROT_LOCKED = '{open: 1'b0, rsv: 3'b000, rdis: 1'b0, size: 3'b111};

endpackage

// File: rtl/wprot_loader.sv
module wprot_loader (
  input  logic clk,
  input  logic rst,
  input  logic nv_ack,
  output logic nv_req,
  output logic load_stb,
  output logic load_done
);

  typedef enum logic [1:0] {LD_REQ = 2'd0, LD_DONE = 2'd1} ld_state_t;

  ld_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LD_REQ;
    end else if (state_q == LD_REQ && nv_ack) begin
      state_q <= LD_DONE;
    end
  end

  assign nv_req    = (state_q == LD_REQ);
  assign load_stb  = (state_q == LD_REQ) && nv_ack;
  assign load_done = (state_q == LD_DONE);

  // R2
  req_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    load_done |-> !nv_req);

  // R2
  done_stays_chk: assert property (@(posedge clk) disable iff (rst)
    $past(load_done) |-> load_done);

endmodule

// File: rtl/wprot_reg_core.sv
module wprot_reg_core
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_stb,
  input  logic       load_done,
  input  logic [7:0] nv_data,
  input  logic       nv_err,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output prot_t      q
);

  prot_t w;
  logic  unused_rsv_w;

  assign w            = prot_t'(wdata);
  assign unused_rsv_w = ^w.rsv;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= PROT_LOCKED;
    end else if (load_stb) begin
      q <= nv_err ? PROT_LOCKED : prot_t'(nv_data);
    end else if (wr_en && load_done) begin
      q.open <= q.open & w.open;
      q.rdis <= q.rdis & w.rdis;
      if (q.rdis) begin
        q.size <= w.size;
      end
    end
  end

  // R4
  open_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(load_done) && !$past(q.open)) |-> !q.open);

  // R5
  rdis_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(load_done) && !$past(q.rdis)) |-> !q.rdis);

  // R6
  size_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(load_done) && !$past(q.rdis)) |-> $stable(q.size));

  // R7
  rsv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(load_done) |-> $stable(q.rsv));

  // R3
  err_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb && nv_err) |=> (q == PROT_LOCKED));

endmodule

// File: rtl/wprot_range_dec.sv
module wprot_range_dec #(
  parameter int WIN_AW = 10,
  parameter int SEG_AW = 6
) (
  input  logic              ready,
  input  logic              open,
  input  logic              rdis,
  input  logic [2:0]        size,
  input  logic              ram_we,
  input  logic [WIN_AW-1:0] ram_addr,
  output logic              wr_block
);

  localparam int CW = WIN_AW + 1;
  localparam logic [CW-1:0] WIN_END = CW'(1) << WIN_AW;

  logic [CW-1:0] seg_cnt;
  logic [CW-1:0] range_lo;
  logic          in_range;
  logic          prot_hit;

  assign seg_cnt  = CW'(size) + CW'(1);
  assign range_lo = WIN_END - (seg_cnt << SEG_AW);
  assign in_range = ({1'b0, ram_addr} >= range_lo);

  always_comb begin
    if (!ready || !open) begin
      prot_hit = 1'b1;
    end else if (rdis) begin
      prot_hit = 1'b0;
    end else begin
      prot_hit = in_range;
    end
  end

  assign wr_block = ram_we & prot_hit;

endmodule

// File: rtl/bufram_wprot_ctrl.sv
module bufram_wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int BUS_AW  = 4,
  parameter int REG_OFS = 9,
  parameter int WIN_AW  = 10,
  parameter int SEG_AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              nv_req,
  input  logic              nv_ack,
  input  logic [7:0]        nv_data,
  input  logic              nv_err,
  output logic              load_done,
  input  logic              ram_we,
  input  logic [WIN_AW-1:0] ram_addr,
  output logic              wr_block
);

  prot_t q;
  logic  load_stb;
  logic  reg_hit;

  assign reg_hit = (bus_addr == BUS_AW'(REG_OFS));

  wprot_loader loader_i (
    .clk       (clk),
    .rst       (rst),
    .nv_ack    (nv_ack),
    .nv_req    (nv_req),
    .load_stb  (load_stb),
    .load_done (load_done)
  );

  wprot_reg_core core_i (
    .clk       (clk),
    .rst       (rst),
    .load_stb  (load_stb),
    .load_done (load_done),
    .nv_data   (nv_data),
    .nv_err    (nv_err),
    .wr_en     (bus_we && reg_hit),
    .wdata     (bus_wdata),
    .q         (q)
  );

  wprot_range_dec #(
    .WIN_AW (WIN_AW),
    .SEG_AW (SEG_AW)
  ) dec_i (
    .ready    (load_done),
    .open     (q.open),
    .rdis     (q.rdis),
    .size     (q.size),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .wr_block (wr_block)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else begin
      bus_rdata <= reg_hit ? 8'(q) : 8'h00;
    end
  end

  // R1
  preload_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_done && ram_we) |-> wr_block);

  // R8
  closed_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!q.open && ram_we) |-> wr_block);

  // R10
  no_we_no_block_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we |-> !wr_block);

  // R11
  rdata_miss_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!reg_hit) && !$past(rst)) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/bufram_wprot_ctrl_tb_top.sv
module bufram_wprot_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = 4'h9;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       nv_req;
  logic       nv_ack = 1'b0;
  logic [7:0] nv_data = 8'h00;
  logic       nv_err = 1'b0;
  logic       load_done;
  logic       ram_we = 1'b0;
  logic [9:0] ram_addr = '0;
  logic       wr_block;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  bufram_wprot_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nv_req(nv_req),
    .nv_ack(nv_ack), .nv_data(nv_data), .nv_err(nv_err),
    .load_done(load_done), .ram_we(ram_we), .ram_addr(ram_addr),
    .wr_block(wr_block)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_wr(input logic [7:0] cur, input logic [7:0] w);
    return {cur[7] & w[7], cur[6:4], cur[3] & w[3], cur[3] ? w[2:0] : cur[2:0]};
  endfunction

  function automatic bit exp_blk(input logic [7:0] v, input int a);
    if (!v[7]) return 1'b1;
    if (v[3])  return 1'b0;
    return a >= (1024 - (int'(v[2:0]) + 1) * 64);
  endfunction

  // reset, check the pre-load state, then load a byte
  task automatic reset_load(input logic [7:0] v, input bit err, input bit pre);
    @(negedge clk);
    rst = 1'b1; nv_ack = 1'b0; bus_we = 1'b0; bus_addr = 4'h9;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    if (pre) begin
      // R1
      chk("R1 rdata", bus_rdata, 8'h07);
      chk("R1 done", load_done, 0);
      chk("R1 req", nv_req, 1);
      ram_we = 1'b1; ram_addr = 10'd5; #1;
      chk("R1 block", wr_block, 1);
      ram_we = 1'b0;
    end
    nv_data = v; nv_err = err; nv_ack = 1'b1;
    @(negedge clk);
    nv_ack = 1'b0; nv_err = 1'b0;
    if (pre) begin
      // R2
      chk("R2 done", load_done, 1);
      chk("R2 req", nv_req, 0);
    end
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h9;
    @(negedge clk);
  endtask

  initial begin
    // R2 R7 R8 R9 R10: every loaded byte against every buffer address
    for (int v = 0; v < 256; v++) begin
      reset_load(8'(v), 1'b0, v < 4);
      chk("R2 R7 load readback", bus_rdata, v);
      ram_we = 1'b1;
      for (int a = 0; a < 1024; a++) begin
        ram_addr = 10'(a); #1;
        if (!v[7])     chk("R8 closed", wr_block, 1);
        else if (v[3]) chk("R10 open range off", wr_block, 0);
        else           chk("R9 range edge", wr_block, int'(exp_blk(8'(v), a)));
      end
      ram_we = 1'b0; #1;
      chk("R10 no we", wr_block, 0);
    end

    // R3: error load forces locked value
    reset_load(8'hFF, 1'b1, 1'b1);
    chk("R3 err load", bus_rdata, 8'h07);
    ram_we = 1'b1; ram_addr = 10'd0; #1;
    chk("R3 err block", wr_block, 1);
    ram_we = 1'b0;

    // R4 R5 R6 R7: every write byte over flag/size states
    for (int s = 0; s < 32; s++) begin
      logic [7:0] cur;
      cur = {s[4], 3'b101, s[3], s[2:0]};
      for (int w = 0; w < 256; w++) begin
        logic [7:0] nxt;
        reset_load(cur, 1'b0, 1'b0);
        bus_write(4'h9, 8'(w));
        nxt = exp_wr(cur, 8'(w));
        chk("R4 R5 R6 R7 write", bus_rdata, nxt);
        ram_we = 1'b1;
        ram_addr = 10'(((w % 16) * 64) + (w % 64)); #1;
        chk("R9 after write", wr_block, int'(exp_blk(nxt, int'(ram_addr))));
        ram_we = 1'b0;
      end
    end

    // R6: clear range-disable and set size in one write, then size frozen
    reset_load(8'h88, 1'b0, 1'b0);
    bus_write(4'h9, 8'hF5);
    chk("R6 same-cycle size", bus_rdata, 8'h85);
    bus_write(4'h9, 8'hFA);
    chk("R6 size locked", bus_rdata, 8'h85);
    bus_write(4'h9, 8'h7F);
    chk("R4 open clears", bus_rdata, 8'h05);
    bus_write(4'h9, 8'hFF);
    chk("R4 open stays", bus_rdata, 8'h05);

    // R11: other addresses read zero and ignore writes
    reset_load(8'hFF, 1'b0, 1'b0);
    bus_write(4'h3, 8'h00);
    chk("R11 other write", bus_rdata, 8'hFF);
    bus_addr = 4'h3;
    @(negedge clk);
    chk("R11 other read", bus_rdata, 8'h00);
    bus_addr = 4'h9;
    @(negedge clk);
    chk("R11 reg read", bus_rdata, 8'hFF);

    finish_run();
  end

endmodule